// File: doc/BRIEF.md
# Byte-Count-Aware SPI Master Shift Engine

This block is the serial core of a single-lane SPI master. It takes 32-bit words from a transmit queue, shifts out only the number of bytes each word carries, and pushes one 32-bit receive word per transmit word into a receive queue. The word's lowest byte lane goes out first, and each byte is sent most-significant bit first. The serial clock comes from the reference clock divided by a power of two. Clock polarity and clock phase are both selectable. The chip-select lines are driven either manually or automatically for the length of a word.

Configuration arrives on a 16-bit control input whose fields sit at fixed bit positions. A separate global enable input gates all activity. Clearing the enable aborts a word in flight and releases every chip select. Transfers start on their own whenever the queue holds data, unless manual start is selected. In manual start, a one-cycle `go` pulse launches the next word.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, `busy`, `tx_pop` and `rx_push` are low, `sclk` is low and every `cs_n` line is high.
- R2: The divider field `ctrl[5:3]` = n gives a serial clock half-period of 2^n reference cycles, so the full period is 2^(n+1) cycles. Divider values 0 and 7 give periods of 2 and 256 cycles.
- R3: `ctrl[1]` sets the `sclk` idle level, and each transfer starts and ends at that level.
- R4: With `ctrl[2]` = 0, `mosi` changes on trailing edges and `miso` is sampled on leading edges. With `ctrl[2]` = 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R5: `tx_len` holds the byte count minus one. Bytes go out in lane order bits 7:0, 15:8, 23:16, 31:24, MSB first within each byte, and shifting stops after the counted bytes.
- R6: Each received bit lands in the same bit position it was sent from, and byte lanes beyond the count read as zero. `rx_push` pulses for one cycle in the cycle `busy` falls, with the word on `rx_data`.
- R7: `busy` rises in the cycle after the pop and stays high for exactly 16 × bytes half-periods.
- R8: With `ctrl[15]` = 0, `ctrl[0]` = 1 and `en` = 1, an idle engine pops a word (one-cycle `tx_pop`) in any cycle where `tx_valid` is high.
- R9: With `ctrl[15]` = 1, no word is popped until `go` is high while `tx_valid` is high.
- R10: Chip selects are one-cold, active low, taken from `ctrl[13:10]` (line k from bit 10+k). With `ctrl[14]` = 1 they follow that field at all times. With `ctrl[14]` = 0 they follow it only while `busy`, and are otherwise all high.
- R11: With `en` = 0, every `cs_n` line is high and no word is popped. A word in flight is abandoned in the next cycle, with no `rx_push`.
- R12: With `ctrl[0]` = 0, no word is popped and the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 16 | Control word: master enable, polarity, phase, divider, chip selects, manual modes |
| en | input | 1 | Global enable |
| go | input | 1 | Start pulse used in manual start |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Transmit word at queue head |
| tx_len | input | 2 | Byte count of that word minus one |
| tx_pop | output | 1 | Removes the head word from the transmit queue |
| rx_push | output | 1 | Writes `rx_data` into the receive queue |
| rx_data | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| busy | output | 1 | Transfer in progress |

## Verification
The bench loops `mosi` back to `miso`, optionally inverted, and compares `sclk`, `busy` and `cs_n` against a cycle-count model on every clock. It also checks `mosi` at every sampling edge. Short words of one, two and three bytes at several dividers, including both extremes, target a design that sends too many bytes or leaves stale data in unused lanes. Such a design would stretch `busy` or return non-zero upper lanes. All four polarity/phase pairs are run, so a design that samples on the wrong edge would return shifted bits. The tests also cover: an abort mid-word that must leave no push, manual start held off until `go`, and a cleared master-enable bit that must block popping.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} eng_state_t;
  localparam int CTL_W      = 16;
  localparam int CTL_MSTR   = 0;
  localparam int CTL_CPOL   = 1;
  localparam int CTL_CPHA   = 2;
  localparam int CTL_DIV_LO = 3;
  localparam int CTL_CS_LO  = 10;
  localparam int CTL_MAN_CS = 14;
  localparam int CTL_MAN_GO = 15;
endpackage

// File: rtl/spi_div_tick.sv
`timescale 1ns/1ps
module spi_div_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  // half-period minus one: 2^div - 1
  assign lim  = ~({CNT_W{1'b1}} << div);
  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: counter never passes the half-period limit while running
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim));
endmodule

// File: rtl/spi_cs_drive.sv
`timescale 1ns/1ps
module spi_cs_drive #(
  parameter int NUM_CS = 4
) (
  input  logic              en,
  input  logic              manual,
  input  logic              busy,
  input  logic [NUM_CS-1:0] sel_n,
  output logic [NUM_CS-1:0] cs_n
);
  logic drive_ok;
  assign drive_ok = en && (manual || busy);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = ~(drive_ok & ~sel_n[i]);
  end
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int DIV_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic                       mstr_en,
  input  logic                       cpol,
  input  logic                       cpha,
  input  logic [DIV_W-1:0]           div,
  input  logic                       go_ok,
  input  logic                       tx_valid,
  input  logic [BYTES*8-1:0]         tx_data,
  input  logic [$clog2(BYTES)-1:0]   tx_len,
  input  logic                       tick,
  input  logic                       miso,
  output logic                       tx_pop,
  output logic                       busy,
  output logic [DIV_W-1:0]           div_run,
  output logic                       sclk,
  output logic                       mosi,
  output logic                       rx_push,
  output logic [BYTES*8-1:0]         rx_data
);
  localparam int W     = BYTES * 8;
  localparam int IDX_W = $clog2(W);

  function automatic logic [IDX_W-1:0] bit_at(input logic [IDX_W-1:0] b);
    return {b[IDX_W-1:3], ~b[2:0]};
  endfunction

  eng_state_t       st_q, st_d;
  logic [IDX_W-1:0] bcnt_q, bcnt_d, last_q, last_d;
  logic             half_q, half_d;
  logic [W-1:0]     word_q, word_d, rx_q, rx_d;
  logic             mosi_q, mosi_d, sclk_q, sclk_d;
  logic             cpha_q, cpha_d, push_q, push_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             start;

  assign start = (st_q == ST_IDLE) && en && mstr_en && tx_valid && go_ok;

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    last_d = last_q;
    half_d = half_q;
    word_d = word_q;
    rx_d   = rx_q;
    mosi_d = mosi_q;
    sclk_d = sclk_q;
    cpha_d = cpha_q;
    div_d  = div_q;
    push_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sclk_d = cpol;
        if (start) begin
          st_d   = ST_SHIFT;
          bcnt_d = '0;
          half_d = 1'b0;
          word_d = tx_data;
          last_d = {tx_len, 3'b111};
          rx_d   = '0;
          cpha_d = cpha;
          div_d  = div;
          if (!cpha) mosi_d = tx_data[7];
        end
      end
      default: begin
        if (!en) begin
          st_d   = ST_IDLE;
          sclk_d = cpol;
        end else if (tick) begin
          sclk_d = ~sclk_q;
          if (!half_q) begin
            half_d = 1'b1;
            if (!cpha_q) rx_d[bit_at(bcnt_q)] = miso;
            else         mosi_d = word_q[bit_at(bcnt_q)];
          end else begin
            half_d = 1'b0;
            if (cpha_q) rx_d[bit_at(bcnt_q)] = miso;
            if (bcnt_q == last_q) begin
              st_d   = ST_IDLE;
              push_d = 1'b1;
            end else begin
              bcnt_d = bcnt_q + 1'b1;
              if (!cpha_q) mosi_d = word_q[bit_at(bcnt_q + 1'b1)];
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bcnt_q <= '0;
      last_q <= '0;
      half_q <= 1'b0;
      word_q <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
      sclk_q <= 1'b0;
      cpha_q <= 1'b0;
      div_q  <= '0;
      push_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      last_q <= last_d;
      half_q <= half_d;
      word_q <= word_d;
      rx_q   <= rx_d;
      mosi_q <= mosi_d;
      sclk_q <= sclk_d;
      cpha_q <= cpha_d;
      div_q  <= div_d;
      push_q <= push_d;
    end
  end

  assign tx_pop  = start;
  assign busy    = (st_q == ST_SHIFT);
  assign div_run = div_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_push = push_q;
  assign rx_data = rx_q;

  // R8: a pop always launches a transfer
  p_pop_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);
  // R2: sclk only moves on a divider tick while running
  p_sclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && !tick) |=> $stable(sclk));
  // R6: push only at the end of a transfer, one cycle wide
  p_push_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (!busy && $past(busy)));
  p_push_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
  // R11: dropping enable ends any transfer
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

// File: rtl/spi_word_engine.sv
`timescale 1ns/1ps
module spi_word_engine
  import spi_eng_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int DIV_W  = 3,
  parameter int NUM_CS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              ctrl,
  input  logic                     en,
  input  logic                     go,
  input  logic                     tx_valid,
  input  logic [BYTES*8-1:0]       tx_data,
  input  logic [$clog2(BYTES)-1:0] tx_len,
  output logic                     tx_pop,
  output logic                     rx_push,
  output logic [BYTES*8-1:0]       rx_data,
  output logic                     sclk,
  output logic                     mosi,
  input  logic                     miso,
  output logic [NUM_CS-1:0]        cs_n,
  output logic                     busy
);
  logic             tick, go_ok;
  logic [DIV_W-1:0] div_run;
  logic             unused_ctrl;

  assign go_ok       = !ctrl[CTL_MAN_GO] || go;
  assign unused_ctrl = ^ctrl[CTL_CS_LO-1:CTL_DIV_LO+DIV_W];

  spi_div_tick #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div_run),
    .tick (tick)
  );

  spi_shift_core #(.BYTES(BYTES), .DIV_W(DIV_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mstr_en (ctrl[CTL_MSTR]),
    .cpol    (ctrl[CTL_CPOL]),
    .cpha    (ctrl[CTL_CPHA]),
    .div     (ctrl[CTL_DIV_LO +: DIV_W]),
    .go_ok   (go_ok),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_len  (tx_len),
    .tick    (tick),
    .miso    (miso),
    .tx_pop  (tx_pop),
    .busy    (busy),
    .div_run (div_run),
    .sclk    (sclk),
    .mosi    (mosi),
    .rx_push (rx_push),
    .rx_data (rx_data)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) u_cs (
    .en    (en),
    .manual(ctrl[CTL_MAN_CS]),
    .busy  (busy),
    .sel_n (ctrl[CTL_CS_LO +: NUM_CS]),
    .cs_n  (cs_n)
  );

  // R11: disabled engine never selects a device
  p_cs_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (&cs_n));
  // R10: automatic select releases every line when idle
  p_cs_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CTL_MAN_CS] && !busy) |-> (&cs_n));
endmodule

// File: tb/spi_word_engine_test.sv
`timescale 1ns/1ps
module spi_word_engine_test;
  logic        clk, rst_n;
  logic [15:0] ctrl;
  logic        en, go, tx_valid, miso_inv;
  logic [31:0] tx_data;
  logic [1:0]  tx_len;
  logic        tx_pop, rx_push, sclk, mosi, miso, busy;
  logic [31:0] rx_data;
  logic [3:0]  cs_n;
  int          total, bad, cyc;

  assign miso = mosi ^ miso_inv;

  spi_word_engine uut (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .en(en), .go(go),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_len(tx_len),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit man_go, input bit man_cs,
      input logic [3:0] sel, input logic [2:0] dv, input bit pha, input bit pol,
      input bit mstr);
    return {man_go, man_cs, sel, 4'b0000, dv, pha, pol, mstr};
  endfunction

  task automatic run_word(input logic [31:0] d, input logic [1:0] l,
      input logic [2:0] dv, input bit pol, input bit pha, input bit inv,
      input bit man);
    int half = 1 << dv;
    int nb   = 8 * (int'(l) + 1);
    int span = nb * 2 * half;
    logic [31:0] mask, exp_rx;
    mask = 32'h0;
    for (int i = 0; i <= int'(l); i++) mask[i*8 +: 8] = 8'hFF;
    exp_rx = (d ^ (inv ? 32'hFFFF_FFFF : 32'h0)) & mask;
    ctrl = mk_ctrl(man, 1'b0, 4'b1101, dv, pha, pol, 1'b1);
    en = 1'b1; miso_inv = inv; tx_data = d; tx_len = l; tx_valid = 1'b1;
    if (man) begin
      for (int k = 0; k < 5; k++) begin
        #1;
        chk(tx_pop === 1'b0, "R9 no pop before go", tx_pop, 0);
        chk(busy === 1'b0, "R9 idle before go", busy, 0);
        @(negedge clk);
      end
      go = 1'b1;
    end
    #1;
    chk(tx_pop === 1'b1, man ? "R9 pop on go" : "R8 auto pop", tx_pop, 1);
    @(negedge clk);
    tx_valid = 1'b0; go = 1'b0;
    for (int t = 0; t < span; t++) begin
      logic es;
      es = pol ^ (((t / half) % 2) == 1);
      chk(busy === 1'b1, "R7 busy span", busy, 1);
      chk(sclk === es, "R2 R3 sclk level", sclk, es);
      chk(cs_n === 4'b1101, "R10 auto select", cs_n, 4'b1101);
      if ((!pha && (t % (2*half)) == half - 1) ||
          (pha && (t % (2*half)) == 2*half - 1)) begin
        int b  = t / (2*half);
        int ix = (b / 8) * 8 + (7 - (b % 8));
        chk(mosi === d[ix], "R4 R5 mosi bit", mosi, d[ix]);
      end
      @(negedge clk);
    end
    chk(busy === 1'b0, "R7 busy end", busy, 0);
    chk(rx_push === 1'b1, "R6 push at end", rx_push, 1);
    chk(rx_data === exp_rx, "R6 rx lanes", rx_data, exp_rx);
    chk(sclk === pol, "R3 idle after", sclk, pol);
    chk(cs_n === 4'hF, "R10 auto release", cs_n, 4'hF);
    @(negedge clk);
    chk(rx_push === 1'b0, "R6 single push", rx_push, 0);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; ctrl = 16'h0; en = 1'b0; go = 1'b0; tx_valid = 1'b0;
    tx_data = '0; tx_len = '0; miso_inv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(sclk === 1'b0, "R1 sclk", sclk, 0);
    chk(cs_n === 4'hF, "R1 cs", cs_n, 4'hF);
    chk(tx_pop === 1'b0, "R1 pop", tx_pop, 0);
    chk(rx_push === 1'b0, "R1 push", rx_push, 0);

    run_word(32'hA5C3_5A96, 2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_word(32'h1234_56B1, 2'd0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_word(32'hDEAD_7E81, 2'd1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_word(32'h0F0F_C639, 2'd2, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    run_word(32'hFFFF_FF4D, 2'd0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0);
    run_word(32'h8001_2E57, 2'd2, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1);

    // R3 idle level with polarity high
    ctrl = mk_ctrl(1'b0, 1'b0, 4'b1110, 3'd0, 1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk(sclk === 1'b1, "R3 idle high", sclk, 1);

    // R12 master enable clear blocks start
    ctrl = mk_ctrl(1'b0, 1'b0, 4'b1110, 3'd0, 1'b0, 1'b0, 1'b0);
    tx_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(tx_pop === 1'b0, "R12 no pop", tx_pop, 0);
      @(negedge clk);
      chk(busy === 1'b0, "R12 idle", busy, 0);
    end
    tx_valid = 1'b0;

    // R10 manual chip select
    ctrl = mk_ctrl(1'b0, 1'b1, 4'b1011, 3'd0, 1'b0, 1'b0, 1'b1);
    #1;
    chk(cs_n === 4'b1011, "R10 manual select", cs_n, 4'b1011);
    en = 1'b0;
    #1;
    chk(cs_n === 4'hF, "R11 disabled select", cs_n, 4'hF);
    @(negedge clk);

    // R11 abort mid-word
    en = 1'b1;
    ctrl = mk_ctrl(1'b0, 1'b0, 4'b0111, 3'd2, 1'b0, 1'b0, 1'b1);
    tx_data = 32'hCAFE_F00D; tx_len = 2'd3; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy === 1'b1, "R11 running before abort", busy, 1);
    en = 1'b0; tx_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #1;
      chk(tx_pop === 1'b0, "R11 no pop disabled", tx_pop, 0);
      @(negedge clk);
      chk(busy === 1'b0, "R11 aborted", busy, 0);
      chk(rx_push === 1'b0, "R11 no push", rx_push, 0);
      chk(cs_n === 4'hF, "R11 cs high", cs_n, 4'hF);
    end
    tx_valid = 1'b0; en = 1'b1;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule